// File: doc/BRIEF.md
# Three-Channel Down-Counting Reload Timer

This block holds three independent down counters behind a small register bus. Each channel has a count register, a reload constant and a control word. The control word selects a prescaler ratio, enables the interrupt and holds a sticky underflow flag. A shared start register holds one run bit per channel. While its run bit is set, a channel decrements on every prescaled tick. When the count is already zero, the next tick reloads the constant instead, sets the flag, and raises the channel's interrupt line if the enable bit is set.

A reload constant of zero leaves the channel parked at zero after its first underflow, which gives one-shot use. A constant of all ones gives a free-running counter that wraps. Software loads the count directly, so one write both programs an interval and restarts it.

Reads are combinational from the address. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. The register map is: start register at 0x00, and channel n based at 0x04 + 12·n, with the constant at +0, the count at +4 and the control word at +8.

Top module: `dnc_reload_timer`

## Requirements
- R1: After reset every control word reads 0x0000_0020 (interrupt enabled, ratio code 0, flag clear), every count and constant reads 0xFFFF_FFFF, the start register reads 0 and all interrupt lines are low.
- R2: Start register bit n is channel n's run bit. While the bit is 0 the channel's count does not change except by a software write to the count register.
- R3: A running channel decrements once per prescaled tick. After its run bit is set on edge W, the count changes on edges W+D, W+2D and so on, where D is the ratio.
- R4: Control bits [2:0] select the ratio D: code 0 gives 4, 1 gives 16, 2 gives 64 and 3 gives 256, and codes 4 to 7 behave as 4. The bits read back as written.
- R5: A tick that finds the count at 0 loads the constant register instead of decrementing. A constant of 0 keeps the count at 0, and a constant of 0xFFFF_FFFF wraps from 0 to 0xFFFF_FFFF.
- R6: Control bit 8 is the underflow flag. It is set on the edge where the reload happens. Writing 0 to bit 8 clears it, and writing 1 leaves it unchanged. If a clearing write and a reload fall on the same edge, the flag ends set.
- R7: Control bit 5 is the interrupt enable. `irq[n]` is high exactly while channel n's flag and enable are both 1.
- R8: A software write to a count register is visible on the next read and takes priority over a tick on the same edge.
- R9: Control bits other than 8, 5 and [2:0] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 means write, 0 means read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational; 0 when not selected |
| irq | output | NCH | Per-channel underflow interrupt lines |

## Verification
The checker assumes bus inputs that are known and held for a full cycle, with one write per edge at most. It places no restriction on the addresses used. Its reload and decrement properties assume that a count write in the same cycle wins, so they are qualified by the count write strobe. The bench drives every access on the falling edge, one register per cycle, and times each access against an edge counter. This lets it place writes exactly on tick and reload edges and check those collisions.

// File: rtl/dnc_timer_pkg.sv
package dnc_timer_pkg;
   localparam int SEL_W    = 3;
   localparam int IE_POS   = 5;
   localparam int FLAG_POS = 8;
   localparam int PS_W     = 8;

   typedef struct packed {
      logic             flag;
      logic             ie;
      logic [SEL_W-1:0] sel;
   } ctrl_t;

   // terminal value of the prescale counter for a ratio code
   function automatic logic [PS_W-1:0] ps_limit(input logic [SEL_W-1:0] code);
      case (code)
         3'd1:    return 8'd15;
         3'd2:    return 8'd63;
         3'd3:    return 8'd255;
         default: return 8'd3;
      endcase
   endfunction

   function automatic logic [31:0] ctrl_word(input ctrl_t c);
      logic [31:0] w;
      w = '0;
      w[SEL_W-1:0] = c.sel;
      w[IE_POS]    = c.ie;
      w[FLAG_POS]  = c.flag;
      return w;
   endfunction
endpackage

// File: rtl/dnc_prescale.sv
module dnc_prescale
   import dnc_timer_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] code,
   output logic             tick
);
   logic [PS_W-1:0] pcnt_q;

   assign tick = run && (pcnt_q >= ps_limit(code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (!run || tick)
         pcnt_q <= '0;
      else
         pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/dnc_chan.sv
module dnc_chan
   import dnc_timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             const_we,
   input  logic             cnt_we,
   input  logic             ctrl_we,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] const_q,
   output ctrl_t            ctrl_q,
   output logic             tick,
   output logic             uf,
   output logic             irq
);
   dnc_prescale u_ps (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .code (ctrl_q.sel),
      .tick (tick)
   );

   assign uf  = tick && (cnt_q == '0) && !cnt_we;
   assign irq = ctrl_q.flag && ctrl_q.ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (cnt_we) begin
         cnt_q <= wdata[CNT_W-1:0];
      end else if (tick) begin
         if (cnt_q == '0) cnt_q <= const_q;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        const_q <= '1;
      else if (const_we) const_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q.sel  <= '0;
         ctrl_q.ie   <= 1'b1;
         ctrl_q.flag <= 1'b0;
      end else begin
         if (ctrl_we) begin
            ctrl_q.sel <= wdata[SEL_W-1:0];
            ctrl_q.ie  <= wdata[IE_POS];
         end
         if (uf)
            ctrl_q.flag <= 1'b1;
         else if (ctrl_we && !wdata[FLAG_POS])
            ctrl_q.flag <= 1'b0;
      end
   end
endmodule

// File: rtl/dnc_regmap.sv
module dnc_regmap #(
   parameter int NCH       = 3,
   parameter int ADDR_W    = 8,
   parameter int CH_BASE   = 4,
   parameter int STRIDE    = 12,
   parameter int START_OFS = 0,
   parameter int CNT_W     = 32
) (
   input  logic                       sel,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NCH-1:0][CNT_W-1:0]  cnt_q,
   input  logic [NCH-1:0][CNT_W-1:0]  const_q,
   input  logic [NCH-1:0][31:0]       ctrl_w,
   input  logic [NCH-1:0]             run_q,
   output logic [NCH-1:0]             const_we,
   output logic [NCH-1:0]             cnt_we,
   output logic [NCH-1:0]             ctrl_we,
   output logic                       start_we,
   output logic [31:0]                rdata
);
   localparam int OFS_CONST = 0;
   localparam int OFS_CNT   = 4;
   localparam int OFS_CTRL  = 8;

   logic we;
   logic [NCH-1:0] hit_const, hit_cnt, hit_ctrl;
   logic hit_start;

   assign we        = sel && wr;
   assign hit_start = (addr == ADDR_W'(START_OFS));
   assign start_we  = we && hit_start;

   always_comb begin
      for (int n = 0; n < NCH; n++) begin
         hit_const[n] = (addr == ADDR_W'(CH_BASE + n*STRIDE + OFS_CONST));
         hit_cnt[n]   = (addr == ADDR_W'(CH_BASE + n*STRIDE + OFS_CNT));
         hit_ctrl[n]  = (addr == ADDR_W'(CH_BASE + n*STRIDE + OFS_CTRL));
      end
      const_we = hit_const & {NCH{we}};
      cnt_we   = hit_cnt   & {NCH{we}};
      ctrl_we  = hit_ctrl  & {NCH{we}};
   end

   always_comb begin
      rdata = '0;
      if (sel && !wr) begin
         if (hit_start) rdata = 32'(run_q);
         for (int n = 0; n < NCH; n++) begin
            if (hit_const[n]) rdata = 32'(const_q[n]);
            if (hit_cnt[n])   rdata = 32'(cnt_q[n]);
            if (hit_ctrl[n])  rdata = ctrl_w[n];
         end
      end
   end
endmodule

// File: rtl/dnc_reload_timer.sv
module dnc_reload_timer
   import dnc_timer_pkg::*;
#(
   parameter int NCH       = 3,
   parameter int CNT_W     = 32,
   parameter int ADDR_W    = 8,
   parameter int CH_BASE   = 4,
   parameter int STRIDE    = 12,
   parameter int START_OFS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    irq
);
   localparam int MAP_END = CH_BASE + NCH*STRIDE;

   generate
      if (NCH < 1 || NCH > 8)
         $error("NCH must lie in 1..8");
      if (CNT_W < 2 || CNT_W > 32)
         $error("CNT_W must lie in 2..32");
      if (STRIDE < 12 || (STRIDE % 4) != 0)
         $error("STRIDE must be a multiple of 4 and at least 12");
      if (MAP_END > (1 << ADDR_W))
         $error("register map does not fit ADDR_W");
      if (START_OFS >= CH_BASE && START_OFS < MAP_END)
         $error("start register overlaps a channel window");
   endgenerate

   logic [NCH-1:0]            run_q;
   logic [NCH-1:0]            const_we, cnt_we, ctrl_we;
   logic                      start_we;
   logic [NCH-1:0][CNT_W-1:0] cnt_v, const_v;
   logic [NCH-1:0][31:0]      ctrl_w;
   logic [NCH-1:0]            tick_v, uf_v, flag_v, ie_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= '0;
      else if (start_we) run_q <= bus_wdata[NCH-1:0];
   end

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      ctrl_t c;
      dnc_chan #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run_q[n]),
         .const_we(const_we[n]),
         .cnt_we  (cnt_we[n]),
         .ctrl_we (ctrl_we[n]),
         .wdata   (bus_wdata),
         .cnt_q   (cnt_v[n]),
         .const_q (const_v[n]),
         .ctrl_q  (c),
         .tick    (tick_v[n]),
         .uf      (uf_v[n]),
         .irq     (irq[n])
      );
      assign ctrl_w[n] = ctrl_word(c);
      assign flag_v[n] = c.flag;
      assign ie_v[n]   = c.ie;
   end

   dnc_regmap #(
      .NCH(NCH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE),
      .STRIDE(STRIDE), .START_OFS(START_OFS), .CNT_W(CNT_W)
   ) u_map (
      .sel     (bus_sel),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .cnt_q   (cnt_v),
      .const_q (const_v),
      .ctrl_w  (ctrl_w),
      .run_q   (run_q),
      .const_we(const_we),
      .cnt_we  (cnt_we),
      .ctrl_we (ctrl_we),
      .start_we(start_we),
      .rdata   (bus_rdata)
   );
endmodule

// File: rtl/dnc_timer_chk.sv
module dnc_timer_chk #(
   parameter int NCH   = 3,
   parameter int CNT_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NCH-1:0]            run,
   input logic [NCH-1:0]            tick,
   input logic [NCH-1:0]            uf,
   input logic [NCH-1:0]            cnt_we,
   input logic [NCH-1:0]            ctrl_we,
   input logic [31:0]               wdata,
   input logic [NCH-1:0][CNT_W-1:0] cnt,
   input logic [NCH-1:0][CNT_W-1:0] cval,
   input logic [NCH-1:0]            flag,
   input logic [NCH-1:0]            ie,
   input logic [NCH-1:0]            irq
);
   for (genvar n = 0; n < NCH; n++) begin : g_chk
      assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!run[n] && !cnt_we[n]) |=> $stable(cnt[n]));
      assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (tick[n] && cnt[n] != '0 && !cnt_we[n]) |=> cnt[n] == $past(cnt[n]) - 1'b1);
      assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         tick[n] |=> !tick[n]);
      assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
         uf[n] |=> cnt[n] == $past(cval[n]));
      assert_flag_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[n]) |-> $past(uf[n]));
      assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_we[n] && !wdata[8] && !uf[n]) |=> !flag[n]);
      assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq[n] |-> (ie[n] && flag[n]));
      assert_wr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_we[n] |=> cnt[n] == $past(wdata[CNT_W-1:0]));
   end
endmodule

bind dnc_reload_timer dnc_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (run_q),
   .tick   (tick_v),
   .uf     (uf_v),
   .cnt_we (cnt_we),
   .ctrl_we(ctrl_we),
   .wdata  (bus_wdata),
   .cnt    (cnt_v),
   .cval   (const_v),
   .flag   (flag_v),
   .ie     (ie_v),
   .irq    (irq)
);

// File: tb/sim_dnc_reload_timer.sv
module sim_dnc_reload_timer;
   localparam int NCH = 3;
   localparam logic [7:0] A_START = 8'h00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   always #4 clk = ~clk;

   dnc_reload_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] mask;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t  sb[$];
   bit     mon_go = 1'b0;
   int     n_run = 0, n_fail = 0;
   int     ncyc = 0, t0 = 0;
   bit     done = 1'b0;

   always @(posedge clk) ncyc <= ncyc + 1;

   function automatic logic [7:0] a_const(int n); return 8'(4 + 12*n); endfunction
   function automatic logic [7:0] a_cnt(int n);   return 8'(8 + 12*n); endfunction
   function automatic logic [7:0] a_ctrl(int n);  return 8'(12 + 12*n); endfunction

   // monitor: samples 1 ns before the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (mon_go && sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? (32'(irq) & it.mask) : bus_rdata;
            n_run++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 1'b0; it.mask = '1; it.exp = e; it.tag = tag;
      sb.push_back(it);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; mon_go = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; mon_go = 1'b0;
   endtask

   task automatic chk_irq(input logic [31:0] m, input logic [31:0] e, input string tag);
      item_t it;
      it.is_irq = 1'b1; it.mask = m; it.exp = e; it.tag = tag;
      sb.push_back(it);
      mon_go = 1'b1;
      @(negedge clk);
      mon_go = 1'b0;
   endtask

   task automatic go(input logic [31:0] runmask);
      wr(A_START, runmask);
      t0 = ncyc;
   endtask

   task automatic at(input int k);
      while (ncyc - t0 < k) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(a_ctrl(0), 32'h20, "R1 ctrl0");
      rd(a_cnt(1), 32'hFFFF_FFFF, "R1 cnt1");
      rd(a_const(2), 32'hFFFF_FFFF, "R1 const2");
      rd(A_START, 32'h0, "R1 start");
      chk_irq(32'h7, 32'h0, "R1 irq");

      // R3 decrement at /4, R5 reload, R6 flag, R7 irq
      wr(a_const(0), 32'd5);
      wr(a_cnt(0), 32'd2);
      wr(a_ctrl(0), 32'h20);
      go(32'h1);
      rd(a_cnt(0), 32'd2, "R3 cnt at start");
      at(4);  rd(a_cnt(0), 32'd1, "R3 first tick");
      at(8);  rd(a_cnt(0), 32'd0, "R3 second tick");
      at(11); rd(a_ctrl(0), 32'h20, "R6 flag not yet");
      at(12); rd(a_ctrl(0), 32'h120, "R6 flag on reload");
      at(13); chk_irq(32'h1, 32'h1, "R7 irq0 high");
      at(14); rd(a_cnt(0), 32'd5, "R5 reload value");
      at(15); wr(a_ctrl(0), 32'h20);
      rd(a_ctrl(0), 32'h20, "R6 clear by zero");
      chk_irq(32'h1, 32'h0, "R7 irq0 low after clear");
      // clear write coincides with reload at edge 36
      at(35); wr(a_ctrl(0), 32'h20);
      rd(a_ctrl(0), 32'h120, "R6 set wins over clear");
      at(38); wr(a_ctrl(0), 32'h20);
      wr(a_ctrl(0), 32'h120);
      rd(a_ctrl(0), 32'h20, "R6 writing one keeps clear");
      // R8 count write on a tick edge (edge 44)
      at(43); wr(a_cnt(0), 32'h1000);
      rd(a_cnt(0), 32'h1000, "R8 write beats tick");
      at(48); rd(a_cnt(0), 32'h0FFF, "R8 counts from written value");

      // R2 halt
      go(32'h0);
      wr(a_cnt(0), 32'd100);
      at(30); rd(a_cnt(0), 32'd100, "R2 stopped channel holds");

      // one-shot on channel 1 at /16
      wr(a_const(1), 32'd0);
      wr(a_cnt(1), 32'd1);
      wr(a_ctrl(1), 32'h21);
      go(32'h2);
      at(15); rd(a_cnt(1), 32'd1, "R4 /16 before tick");
      at(16); rd(a_cnt(1), 32'd0, "R4 /16 at tick");
      at(31); rd(a_ctrl(1), 32'h21, "R6 ch1 flag not yet");
      at(32); rd(a_ctrl(1), 32'h121, "R6 ch1 flag set");
      at(33); rd(a_cnt(1), 32'd0, "R5 one-shot reload to zero");
      at(50); rd(a_cnt(1), 32'd0, "R5 one-shot stays zero");
      chk_irq(32'h2, 32'h2, "R7 irq1 high");
      wr(a_ctrl(1), 32'h101);
      chk_irq(32'h2, 32'h0, "R7 irq1 masked by enable");
      rd(a_ctrl(1), 32'h101, "R7 ctrl1 readback");

      // R9 readback and reserved ratio code on channel 2
      go(32'h0);
      wr(a_cnt(2), 32'h10);
      wr(a_ctrl(2), 32'hFFFF_FFFF);
      rd(a_ctrl(2), 32'h27, "R9 unused bits zero");
      go(32'h4);
      at(4); rd(a_cnt(2), 32'hF, "R4 code 7 acts as /4");
      at(8); rd(a_cnt(2), 32'hE, "R4 code 7 second tick");

      // R5 free-running wrap
      go(32'h0);
      wr(a_cnt(2), 32'h0);
      wr(a_ctrl(2), 32'h20);
      go(32'h4);
      at(3); rd(a_cnt(2), 32'h0, "R5 before wrap");
      at(4); rd(a_cnt(2), 32'hFFFF_FFFF, "R5 wrap to all ones");
      at(5); rd(a_ctrl(2), 32'h120, "R6 flag on wrap");
      at(8); rd(a_cnt(2), 32'hFFFF_FFFE, "R5 keeps counting");

      // R4 /64 and /256, two channels at once
      go(32'h0);
      wr(a_ctrl(0), 32'h22);
      wr(a_cnt(0), 32'd3);
      wr(a_ctrl(1), 32'h23);
      wr(a_cnt(1), 32'd3);
      go(32'h3);
      rd(A_START, 32'h3, "R2 start readback");
      at(63);  rd(a_cnt(0), 32'd3, "R4 /64 before tick");
      at(64);  rd(a_cnt(0), 32'd2, "R4 /64 at tick");
      at(255); rd(a_cnt(1), 32'd3, "R4 /256 before tick");
      at(256); rd(a_cnt(1), 32'd2, "R4 /256 at tick");

      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule